// File: doc/BRIEF.md
# Byte-Wide UV-Erasable PROM Behavioural Model

This block is a synthesizable cycle-based model of a byte-wide, ultraviolet-erasable programmable read-only memory. It is meant to stand in for such a memory inside a larger simulation or FPGA prototype. A 17-bit address, an 8-bit write-data bus and an 8-bit read-data bus with a separate drive-enable replace the physical tri-state pins. The operating mode comes from three active-low strobes: chip enable `ceN`, output enable `oeN` and program strobe `pgmN`. Two level flags complete the decode. One says the programming supply is at high voltage. The other says address bit 9 is at the identification voltage.

The model returns stored bytes. In place of the array it can return fixed identification bytes. It also accepts program pulses that can only clear bits. A synchronous erase input sets every byte back to all ones. The array depth and the minimum program-pulse length are parameters. Reset clears only the control and output state, because the array stands for non-volatile storage.

Top module: `prom_top`

## Requirements
- R1: With `ceN`=0, `oeN`=0 and `a9High`=0, the byte stored at the address drives `dataOut` with `dataOe`=1 after the next clock edge, whatever `pgmN` and `vppHigh` are. The stored word is indexed by the low log2(DEPTH) address bits, so higher bits alias.
- R2: With `oeN`=1, `dataOe` is 0 after the next clock edge, whatever the other inputs are.
- R3: With `ceN`=1, `dataOe` is 0 after the next clock edge. No byte changes in this state, even with `vppHigh`=1 and a full program pulse on `pgmN`.
- R4: A program write happens when `pgmN` rises while `ceN`=0, `oeN`=1 and `vppHigh`=1. The program condition must also have held with `pgmN`=0 for at least MIN_PULSE consecutive clock edges just before. The write updates the addressed byte once, at the edge that first samples `pgmN`=1.
- R5: A program pulse with fewer than MIN_PULSE low-sampled edges leaves the array unchanged.
- R6: With `vppHigh`=0, a program pulse on `pgmN` leaves the array unchanged.
- R7: With `ceN`=0, `oeN`=0 and `a9High`=1, `dataOut` is 0x1E when address bit 0 is 0 and 0x05 when address bit 0 is 1. The array is not read in this case.
- R8: `eraseAll`=1 at a clock edge sets every byte to 0xFF. Erase wins over a program write at the same edge.
- R9: `dataOut` and `dataOe` are registered, so they change one clock edge after the inputs that select them. `dataOut` is 0 whenever `dataOe` is 0.
- R10: A program write stores the old byte AND `dataIn`. Bits can go from 1 to 0 but never from 0 to 1.
- R11: While `rstN`=0, `dataOe` and `dataOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of control and output state |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| vppHigh | input | 1 | Programming supply at high voltage |
| a9High | input | 1 | Address bit 9 at identification voltage |
| addr | input | ADDR_W (17) | Byte address |
| dataIn | input | DATA_W (8) | Program data |
| eraseAll | input | 1 | Synchronous erase of the whole array to all ones |
| dataOut | output | DATA_W (8) | Read data, 0 when not driven |
| dataOe | output | 1 | Read data is driven |

## Verification
The bench builds the block with DEPTH=64 and MIN_PULSE=3, keeping the full 17-bit address. The small depth lets the bench read back every byte after an erase. It also lets it reach address aliasing with a modest address value. A minimum pulse of three cycles makes both the shortest accepted pulse and a pulse one cycle too short cheap to drive. Together these cover the pulse-length boundary, the AND-only write rule, the inhibit and supply-off cases, and both identification bytes.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef struct packed {
    logic wrEn;
    logic eraseEn;
    logic drive;
    logic selId;
  } promStrobe_t;

  localparam logic [7:0] MFR_CODE = 8'h1E;
  localparam logic [7:0] DEV_CODE = 8'h05;
endpackage

// File: rtl/prom_ctrl.sv
module prom_ctrl
  import prom_pkg::*;
#(
  parameter int MIN_PULSE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        pgmN,
  input  logic        vppHigh,
  input  logic        a9High,
  input  logic        eraseAll,
  output promStrobe_t strobe
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

  logic             progCond;
  logic             pgmLowQ;
  logic [CNT_W-1:0] pulseCnt;

  // program condition apart from the strobe itself
  assign progCond = !ceN && oeN && vppHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmLowQ  <= 1'b0;
      pulseCnt <= '0;
    end else if (progCond && !pgmN) begin
      pgmLowQ <= 1'b1;
      if (pulseCnt != CNT_MAX) pulseCnt <= pulseCnt + 1'b1;
    end else begin
      pgmLowQ  <= 1'b0;
      pulseCnt <= '0;
    end
  end

  always_comb begin
    strobe.eraseEn = eraseAll;
    strobe.wrEn    = progCond && pgmN && pgmLowQ && (pulseCnt == CNT_MAX) && !eraseAll;
    strobe.drive   = !ceN && !oeN;
    strobe.selId   = a9High;
  end
endmodule

// File: rtl/prom_datapath.sv
module prom_datapath
  import prom_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  promStrobe_t              strobe,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOe
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] idByte;
  logic [DATA_W-1:0] nextOut;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic wordHit;
    assign wordHit = (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (strobe.eraseEn) mem[i] <= '1;
      else if (strobe.wrEn && wordHit) mem[i] <= mem[i] & dataIn;
    end
  end

  assign rdWord  = mem[idx];
  assign idByte  = idx[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
  assign nextOut = !strobe.drive ? '0 : (strobe.selId ? idByte : rdWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= nextOut;
      dataOe  <= strobe.drive;
    end
  end
endmodule

// File: rtl/prom_top.sv
module prom_top
  import prom_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHigh,
  input  logic              a9High,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              eraseAll,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int IDX_W = $clog2(DEPTH);

  promStrobe_t      strobe;
  logic [IDX_W-1:0] idx;
  logic             unusedAddrBits;

  assign idx            = addr[IDX_W-1:0];
  assign unusedAddrBits = ^addr[ADDR_W-1:IDX_W];

  prom_ctrl #(.MIN_PULSE(MIN_PULSE)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHigh(vppHigh), .a9High(a9High), .eraseAll(eraseAll), .strobe(strobe)
  );

  prom_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/prom_chk.sv
module prom_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              a9High,
  input logic              addrLsb,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !ceN && !oeN) |=> dataOe);  // R1
  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && oeN) |=> !dataOe);  // R2
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ceN) |=> !dataOe);  // R3
  AST_ID_MFR: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !ceN && !oeN && a9High && !addrLsb) |=> (dataOut == DATA_W'(8'h1E)));  // R7
  AST_ID_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !ceN && !oeN && a9High && addrLsb) |=> (dataOut == DATA_W'(8'h05)));  // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !dataOe) |-> (dataOut == '0));  // R9
endmodule

bind prom_top prom_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .a9High(a9High),
  .addrLsb(addr[0]), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/prom_top_tb.sv
module prom_top_tb;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int DEPTH = 64;
  localparam int MIN_PULSE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, pgmN = 1'b1, vppHigh = 1'b0, a9High = 1'b0, eraseAll = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataOe;

  int checks = 0, fails = 0, cycles = 0;
  logic [DATA_W-1:0] model [DEPTH];

  always #10 clk = ~clk;

  prom_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .MIN_PULSE(MIN_PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .vppHigh(vppHigh),
    .a9High(a9High), .addr(addr), .dataIn(dataIn), .eraseAll(eraseAll),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ceN = 1'b1; oeN = 1'b1; pgmN = 1'b1; vppHigh = 1'b0; a9High = 1'b0; eraseAll = 1'b0;
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a, input logic vpp, output logic [DATA_W-1:0] d,
                        output logic oe);
    ceN = 1'b0; oeN = 1'b0; pgmN = 1'b1; vppHigh = vpp; a9High = 1'b0; addr = a;
    @(negedge clk);
    d = dataOut; oe = dataOe;
  endtask

  task automatic pulse(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int lowCycles,
                       input logic ce, input logic vpp);
    ceN = ce; oeN = 1'b1; vppHigh = vpp; a9High = 1'b0; addr = a; dataIn = d; pgmN = 1'b0;
    repeat (lowCycles) @(negedge clk);
    pgmN = 1'b1;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 reset dataOe", 32'(dataOe), 0);
    check("R11 reset dataOut", 32'(dataOut), 0);
  endtask

  task automatic t_erase();
    logic [DATA_W-1:0] d; logic oe; int bad = 0;
    eraseAll = 1'b1; @(negedge clk); eraseAll = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'hFF;
      readAt(ADDR_W'(i), 1'b0, d, oe);
      if (d !== 8'hFF || oe !== 1'b1) bad++;
    end
    idle(); @(negedge clk);
    check("R8 all bytes erased", 32'(bad), 0);
  endtask

  task automatic t_program();
    logic [DATA_W-1:0] d; logic oe;
    pulse(17'd5, 8'hA5, MIN_PULSE, 1'b0, 1'b1); model[5] = 8'hA5;
    readAt(17'd5, 1'b0, d, oe);
    check("R4 programmed byte", 32'(d), 32'(model[5]));
    check("R1 read drives", 32'(oe), 1);
    pulse(17'd9, 8'h3C, MIN_PULSE + 2, 1'b0, 1'b1);
    pulse(17'd9, 8'hF0, MIN_PULSE, 1'b0, 1'b1); model[9] = 8'h30;
    readAt(17'd9, 1'b1, d, oe);
    check("R10 AND of two writes", 32'(d), 32'h30);
    pulse(17'd5, 8'hFF, MIN_PULSE, 1'b0, 1'b1);
    readAt(17'd5, 1'b0, d, oe);
    check("R10 no 0 to 1", 32'(d), 32'hA5);
    idle(); @(negedge clk);
  endtask

  task automatic t_blocked();
    logic [DATA_W-1:0] d; logic oe;
    pulse(17'd12, 8'h00, MIN_PULSE - 1, 1'b0, 1'b1);
    readAt(17'd12, 1'b0, d, oe);
    check("R5 short pulse ignored", 32'(d), 32'hFF);
    pulse(17'd13, 8'h00, MIN_PULSE, 1'b0, 1'b0);
    readAt(17'd13, 1'b0, d, oe);
    check("R6 no supply ignored", 32'(d), 32'hFF);
    ceN = 1'b1; oeN = 1'b0; pgmN = 1'b1; vppHigh = 1'b1; addr = 17'd14; @(negedge clk);
    check("R3 standby not driven", 32'(dataOe), 0);
    check("R9 idle output zero", 32'(dataOut), 0);
    pulse(17'd14, 8'h00, MIN_PULSE, 1'b1, 1'b1);
    readAt(17'd14, 1'b0, d, oe);
    check("R3 inhibit ignored", 32'(d), 32'hFF);
    ceN = 1'b0; oeN = 1'b1; pgmN = 1'b0; addr = 17'd5; @(negedge clk);
    check("R2 oe high not driven", 32'(dataOe), 0);
    idle(); @(negedge clk);
  endtask

  task automatic t_ident();
    ceN = 1'b0; oeN = 1'b0; pgmN = 1'b1; a9High = 1'b1; addr = 17'd0; @(negedge clk);
    check("R7 maker byte", 32'(dataOut), 32'h1E);
    addr = 17'h10001; @(negedge clk);
    check("R7 device byte", 32'(dataOut), 32'h05);
    a9High = 1'b0; addr = 17'd9;
    check("R9 no change before edge", 32'(dataOut), 32'h05);
    @(negedge clk);
    check("R9 new value after edge", 32'(dataOut), 32'h30);
    idle(); @(negedge clk);
  endtask

  task automatic t_alias();
    logic [DATA_W-1:0] d; logic oe;
    readAt(17'(DEPTH + 5), 1'b1, d, oe);
    check("R1 aliased read", 32'(d), 32'hA5);
    eraseAll = 1'b1; @(negedge clk); eraseAll = 1'b0;
    readAt(17'd5, 1'b0, d, oe);
    check("R8 re-erase", 32'(d), 32'hFF);
    idle(); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_erase();
    t_program();
    t_blocked();
    t_ident();
    t_alias();
    summary();
  end
endmodule